// File: doc/BRIEF.md
# Tick-Divided Pulse-Width Modulator

This block produces one pulse-width modulated output from a single 32-bit control word. A prescaler divides the core clock by a programmable amount to make a tick. An 8-bit period counter counts 256 ticks per output period. The output is active for the first `duty` ticks of each period. A separate bit forces the output to stay active for the whole period.

Software writes the control word through a strobe and a data bus, and can read it back at any time. Writes act at once. Both counters restart from zero on the write edge, and the output follows the new settings from the next cycle, with no wait for the current period to end. Clearing the enable bit stops the output at once.

Top module: `tickpwm`

## Requirements
- R1: The control word has these fields: bit 31 is run enable, bit 24 is full-duty force, bits [23:16] are duty, and bits [12:0] are the divider. `rd_data` returns the last written word with every other bit read as 0. The written value appears on `rd_data` in the cycle after the write edge.
- R2: With divider value N, the period counter advances once every N+1 clock cycles.
- R3: Each period is 256 ticks long. The output is 1 while the period counter is below duty and 0 otherwise. After a write, this gives `pwm_out` = 1 for t mod (256·(N+1)) < duty·(N+1), where t counts cycles from the write edge.
- R4: A duty value of 0 with the force bit clear keeps the output at 0.
- R5: With run enable and force set, the output is held at 1 and the duty bits have no effect.
- R6: A write that clears run enable drives the output to 0 in the cycle after the write edge, even in the middle of a period.
- R7: Every write restarts the prescaler and the period counter from zero, so a rewrite in the middle of a period starts a fresh period at once.
- R8: A synchronous active-high reset clears the control word, both counters and the output.
- R9: The full 13-bit divider works: N = 8191 gives ticks that are 8192 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Read-back of the control word, with unused bits read as 0 |
| pwm_out | output | 1 | Modulated output, where 1 is the active level |

## Verification
A write is taken at a rising edge. `rd_data` and `pwm_out` show the new settings from the cycle that starts at that edge, so both are due exactly one cycle after the strobe is raised. The bench drives and samples on falling edges. It counts t = 0 from the first falling edge after the write edge and compares `pwm_out` with the closed-form R3 expression at every cycle of two full periods. Reset, disable and mid-period rewrites are sampled on the first falling edge after the edge that acts on them.

// File: rtl/tickpwm_pkg.sv
package tickpwm_pkg;
    localparam int WORD_W   = 32;
    localparam int DIV_W    = 13;
    localparam int DUTY_W   = 8;
    localparam int DIV_LSB  = 0;
    localparam int DUTY_LSB = 16;
    localparam int FULL_BIT = 24;
    localparam int RUN_BIT  = 31;

    typedef struct packed {
        logic              run;
        logic              full;
        logic [DUTY_W-1:0] duty;
        logic [DIV_W-1:0]  div;
    } ctl_t;
endpackage

// File: rtl/tickpwm_regs.sv
module tickpwm_regs
    import tickpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctl_t              ctl,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [WORD_W-1:0] KEEP_MASK =
        (WORD_W'(1) << RUN_BIT) | (WORD_W'(1) << FULL_BIT) |
        (((WORD_W'(1) << DUTY_W) - 1) << DUTY_LSB) |
        (((WORD_W'(1) << DIV_W) - 1) << DIV_LSB);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.run  = wr_data[RUN_BIT];
            ctl_d.full = wr_data[FULL_BIT];
            ctl_d.duty = wr_data[DUTY_LSB +: DUTY_W];
            ctl_d.div  = wr_data[DIV_LSB +: DIV_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[RUN_BIT]             = ctl_q.run;
        rd_data[FULL_BIT]            = ctl_q.full;
        rd_data[DUTY_LSB +: DUTY_W]  = ctl_q.duty;
        rd_data[DIV_LSB +: DIV_W]    = ctl_q.div;
    end

    assign ctl = ctl_q;

    assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == ($past(wr_data) & KEEP_MASK));
endmodule

// File: rtl/tickpwm_prescale.sv
module tickpwm_prescale #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic [DIV_W-1:0] phase
);
    typedef struct packed {
        logic [DIV_W-1:0] ph;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart || !run)      pre_d.ph = '0;
        else if (pre_q.ph == div) pre_d.ph = '0;
        else                      pre_d.ph = pre_q.ph + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    assign tick  = run && (pre_q.ph == div);
    assign phase = pre_q.ph;

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> phase == '0);
    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> phase <= div);
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && !tick) |=> phase == $past(phase) + 1'b1);
endmodule

// File: rtl/tickpwm_period.sv
module tickpwm_period #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic             full,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] count,
    output logic             wave
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } per_t;

    per_t per_d, per_q;

    always_comb begin
        per_d = per_q;
        if (restart || !run) per_d.cnt = '0;
        else if (tick)       per_d.cnt = per_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) per_q <= '0;
        else     per_q <= per_d;
    end

    assign count = per_q.cnt;
    assign wave  = run && (full || (per_q.cnt < duty));

    assert_count_clear_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> count == '0);
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && !tick) |=> $stable(count));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && tick) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/tickpwm.sv
module tickpwm
    import tickpwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    ctl_t              ctl;
    logic              tick;
    logic [DIV_W-1:0]  phase;
    logic [DUTY_W-1:0] count;

    tickpwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl),
        .rd_data (rd_data)
    );

    tickpwm_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.run),
        .restart (wr_en),
        .div     (ctl.div),
        .tick    (tick),
        .phase   (phase)
    );

    tickpwm_period #(.CNT_W(DUTY_W)) u_per (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.run),
        .restart (wr_en),
        .tick    (tick),
        .full    (ctl.full),
        .duty    (ctl.duty),
        .count   (count),
        .wave    (pwm_out)
    );

    assert_stop_now_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[RUN_BIT]) |=> !pwm_out);
    assert_force_high_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[RUN_BIT] && wr_data[FULL_BIT]) |=> pwm_out);
    assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_data[RUN_BIT] && !rd_data[FULL_BIT] &&
         rd_data[DUTY_LSB +: DUTY_W] == '0) |-> !pwm_out);
endmodule

// File: tb/tickpwm_test.sv
`timescale 1ns/1ps
module tickpwm_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        pwm_out;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 0;

    localparam logic [31:0] MASK = 32'h81FF_1FFF;
    localparam int NV = 8;
    localparam logic [31:0] VECS [NV] = '{
        32'h8040_0000,  // R3 duty 64, div 0
        32'h8080_0002,  // R2 R3 duty 128, div 2
        32'h8000_0001,  // R4 duty 0
        32'h80FF_0000,  // R3 duty 255
        32'h8110_0003,  // R5 force with duty 16
        32'h0080_0000,  // R6 disabled
        32'h8001_0000,  // R3 duty 1
        32'hFE40_E002   // R1 junk bits, duty 64, div 2
    };

    tickpwm uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_out(input logic [31:0] w, input int t);
        int dv;
        if (!w[31]) return 1'b0;
        if (w[24])  return 1'b1;
        dv = int'(w[12:0]) + 1;
        return ((t / dv) % 256) < int'(w[23:16]);
    endfunction

    // Drive a write; returns at the falling edge where t = 0.
    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset rd_data", rd_data, 32'h0);
        check("R8 reset pwm_out", {31'b0, pwm_out}, 32'h0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            int n;
            write_word(VECS[v]);
            check("R1 readback", rd_data, VECS[v] & MASK);
            n = 512 * (int'(VECS[v][12:0]) + 1);
            if (n > 4096) n = 4096;
            for (int t = 0; t < n; t++) begin
                check("R3 wave", {31'b0, pwm_out}, {31'b0, exp_out(VECS[v], t)});
                @(negedge clk);
            end
        end

        // R4: duty 0 stays low over a whole period
        write_word(32'h8000_0000);
        for (int t = 0; t < 256; t++) begin
            if (pwm_out !== 1'b0) check("R4 zero duty", {31'b0, pwm_out}, 32'h0);
            @(negedge clk);
        end
        check("R4 zero duty end", {31'b0, pwm_out}, 32'h0);

        // R5: force ignores duty 0
        write_word(32'h8100_0000);
        repeat (300) @(negedge clk);
        check("R5 force over duty 0", {31'b0, pwm_out}, 32'h1);

        // R6: abrupt stop mid-period
        write_word(32'h80FF_0000);
        repeat (10) @(negedge clk);
        check("R6 high before stop", {31'b0, pwm_out}, 32'h1);
        write_word(32'h00FF_0000);
        check("R6 low after stop", {31'b0, pwm_out}, 32'h0);
        check("R1 readback after stop", rd_data, 32'h00FF_0000);

        // R7: rewrite in the low part restarts the period
        write_word(32'h8080_0000);
        repeat (200) @(negedge clk);
        check("R7 low at t=200", {31'b0, pwm_out}, 32'h0);
        write_word(32'h8080_0000);
        check("R7 high after rewrite", {31'b0, pwm_out}, 32'h1);
        repeat (127) @(negedge clk);
        check("R7 high at t=127", {31'b0, pwm_out}, 32'h1);
        @(negedge clk);
        check("R7 low at t=128", {31'b0, pwm_out}, 32'h0);

        // R9: largest divider
        write_word(32'h8001_1FFF);
        repeat (8191) @(negedge clk);
        check("R9 high at t=8191", {31'b0, pwm_out}, 32'h1);
        @(negedge clk);
        check("R9 low at t=8192", {31'b0, pwm_out}, 32'h0);

        // R8: reset while running
        write_word(32'h80FF_0000);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 mid-run reset pwm_out", {31'b0, pwm_out}, 32'h0);
        check("R8 mid-run reset rd_data", rd_data, 32'h0);
        repeat (20) @(negedge clk);
        check("R8 stays idle", {31'b0, pwm_out}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule